// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block holds the control and status logic for an eight-bit successive-approximation converter. A single control byte written over the bus sets three things: the channel select, the choice between single-channel and multi-channel operation, and the choice between one pass and a continuous scan. The block then issues conversions one at a time to an external converter core. For each conversion it drives a channel code to the external analog multiplexer, raises a one-cycle start request, and waits for the core's done strobe. Each returned byte goes into one of four result slots, in order.

The block supports two modes of channel use. In single-channel mode the selected channel is converted four times. In multi-channel mode the four channels of an aligned group are converted once each. In one-pass operation the sequencer stops after the fourth slot. In scan operation it returns to slot 0 and overwrites the older results. Any write to the control byte aborts the work in progress and starts again at slot 0. Two further inputs control when conversions may run. A power-up enable input gates whether any conversion may be issued. A suspend input freezes the sequencer in place until it is released.

Top module: `adc_seq`

## Requirements
- R1: After reset, `status` reads 0x00, every result slot holds 0x00, and `conv_start` is low.
- R2: A write with `wr_en` high stores `wr_data[5:0]`. Bits 3..0 are the channel select, bit 4 = 1 picks multi-channel mode, and bit 5 = 1 picks scan. `status` returns these in bits 5..0. Bit 6 reads 0. Bit 7 is the completion flag, which the write clears; written values of bits 7 and 6 are ignored.
- R3: When `pwr_en` is high and `suspend` is low, `conv_start` is high for exactly one cycle: the cycle after the write edge. The core accepts the request at the following edge.
- R4: In single-channel mode, all four conversions of a pass drive `chan_sel` equal to the channel select.
- R5: In multi-channel mode, the conversion for slot k drives `chan_sel` = {select bits 3..2, k}. Select bits 1..0 are ignored.
- R6: A one-pass sequence stores conversion k of the pass in slot k (`results[8k+7:8k]`), for k = 0..3, and then issues no further conversion.
- R7: The completion flag (status bit 7) rises once the fourth result of a pass is stored. In scan mode it stays high while later passes run.
- R8: In scan mode, after slot 3 the sequencer wraps to slot 0 and overwrites it. It keeps running without end and cycles through the group in multi-channel mode.
- R9: A write made while a conversion is outstanding abandons that conversion. The new sequence restarts at slot 0 with the new settings.
- R10: While `pwr_en` is low, no conversion is issued, but writes are still stored. A pending sequence starts once `pwr_en` rises.
- R11: While `suspend` is high, no conversion is issued, no result is stored, and the slot position is kept. The sequence continues from that slot after release.
- R12: A result slot holds the core's byte unchanged, including the boundary codes 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte to write |
| status | output | 8 | Readable control/status byte |
| pwr_en | input | 1 | Converter power-up enable |
| suspend | input | 1 | Freeze sequencer |
| conv_start | output | 1 | Start request to converter core |
| chan_sel | output | 4 | Channel code to analog multiplexer |
| conv_done | input | 1 | Conversion finished strobe from core |
| conv_data | input | 8 | Converted byte from core |
| results | output | 32 | Four result slots, slot k at bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 4-bit channel code and four slots. At this size every combination of the channel select with the single/multi bit can be swept in one-pass runs, which covers all 32 control settings. Each run's channel order and slot contents are compared with values computed from the control byte and the core's arithmetic data pattern. The same configuration also exercises the other behaviours: scan wrap-around over more than one pass, restart on a mid-conversion write, hold-off while unpowered, and suspension in the middle of a pass.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SEL_W  = 4;
    localparam int NSLOT  = 4;
    localparam int SLOT_W = $clog2(NSLOT);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             scan;
        logic             multi;
        logic [SEL_W-1:0] sel;
    } seq_cfg_t;

    localparam int CFG_W = $bits(seq_cfg_t);

    function automatic logic [SEL_W-1:0] chan_for(seq_cfg_t cfg, logic [SLOT_W-1:0] slot);
        logic [SEL_W-1:0] c;
        c = cfg.sel;
        if (cfg.multi) c[SLOT_W-1:0] = slot;
        return c;
    endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       set_flag,
    output seq_cfg_t   cfg,
    output logic       flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            flag <= 1'b0;
        end else if (wr_en) begin
            cfg  <= seq_cfg_t'(wr_data[CFG_W-1:0]);
            flag <= 1'b0;
        end else if (set_flag) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              pwr_en,
    input  logic              suspend,
    input  logic              conv_done,
    input  logic              scan,
    output logic              conv_start,
    output logic              store,
    output logic              pass_end,
    output logic [SLOT_W-1:0] slot
);
    seq_state_e st;

    always_comb begin
        conv_start = (st == ST_ISSUE) && pwr_en && !suspend;
        store      = (st == ST_WAIT) && conv_done && !suspend && !wr_en;
        pass_end   = store && (slot == SLOT_W'(NSLOT - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            slot <= '0;
        end else if (wr_en) begin
            st   <= ST_ISSUE;
            slot <= '0;
        end else if (conv_start) begin
            st <= ST_WAIT;
        end else if (store) begin
            slot <= slot + 1'b1;
            st   <= (pass_end && !scan) ? ST_IDLE : ST_ISSUE;
        end
    end
endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    store,
    input  logic [SLOT_W-1:0]       slot,
    input  logic [DATA_W-1:0]       din,
    output logic [NSLOT*DATA_W-1:0] results
);
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                                q <= '0;
            else if (store && slot == SLOT_W'(k))   q <= din;
        end
        assign results[k*DATA_W +: DATA_W] = q;
    end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [7:0]              wr_data,
    output logic [7:0]              status,
    input  logic                    pwr_en,
    input  logic                    suspend,
    output logic                    conv_start,
    output logic [SEL_W-1:0]        chan_sel,
    input  logic                    conv_done,
    input  logic [DATA_W-1:0]       conv_data,
    output logic [NSLOT*DATA_W-1:0] results
);
    seq_cfg_t          cfg;
    logic              flag;
    logic              store;
    logic              pass_end;
    logic [SLOT_W-1:0] slot;

    adc_seq_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .set_flag (pass_end),
        .cfg      (cfg),
        .flag     (flag)
    );

    adc_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .pwr_en     (pwr_en),
        .suspend    (suspend),
        .conv_done  (conv_done),
        .scan       (cfg.scan),
        .conv_start (conv_start),
        .store      (store),
        .pass_end   (pass_end),
        .slot       (slot)
    );

    adc_seq_bank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .store   (store),
        .slot    (slot),
        .din     (conv_data),
        .results (results)
    );

    always_comb begin
        chan_sel = chan_for(cfg, slot);
        status   = {flag, {(8 - 1 - CFG_W){1'b0}}, cfg};
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic [7:0]              status,
    input logic                    pwr_en,
    input logic                    suspend,
    input logic                    conv_start,
    input logic [SEL_W-1:0]        chan_sel,
    input logic [NSLOT*DATA_W-1:0] results
);
    // R3: a powered, unsuspended write yields a start in the next cycle
    a_r3_start_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_en ##1 (pwr_en && !suspend && !rst) |-> conv_start);

    // R3: start is a single-cycle request unless a new write intervenes
    a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
        conv_start && !wr_en |=> !conv_start);

    // R2: a write clears the completion flag
    a_r2_flag_cleared: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !status[7]);

    // R7: flag stays up until the next write
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (rst)
        status[7] && !wr_en |=> status[7]);

    // R10: no start request while unpowered
    a_r10_unpowered_quiet: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> !conv_start);

    // R11: suspend blocks starts and freezes the result slots
    a_r11_suspend_no_start: assert property (@(posedge clk) disable iff (rst)
        suspend |-> !conv_start);
    a_r11_suspend_results_stable: assert property (@(posedge clk) disable iff (rst)
        suspend |=> $stable(results));

    // R4: single-channel requests use the stored select
    a_r4_single_chan: assert property (@(posedge clk) disable iff (rst)
        conv_start && !status[4] |-> chan_sel == status[SEL_W-1:0]);

    // R5: multi-channel requests stay inside the aligned group
    a_r5_multi_group: assert property (@(posedge clk) disable iff (rst)
        conv_start && status[4] |-> chan_sel[SEL_W-1:SLOT_W] == status[SEL_W-1:SLOT_W]);
endmodule

bind adc_seq adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .status     (status),
    .pwr_en     (pwr_en),
    .suspend    (suspend),
    .conv_start (conv_start),
    .chan_sel   (chan_sel),
    .results    (results)
);

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  status;
    logic        pwr_en = 1'b1;
    logic        suspend = 1'b0;
    logic        conv_start;
    logic [3:0]  chan_sel;
    logic        conv_done;
    logic [7:0]  conv_data;
    logic [31:0] results;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    adc_seq u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .status(status),
        .pwr_en(pwr_en), .suspend(suspend), .conv_start(conv_start), .chan_sel(chan_sel),
        .conv_done(conv_done), .conv_data(conv_data), .results(results)
    );

    // Core data pattern: boundary codes recur, the rest is arithmetic
    function automatic logic [7:0] dfun(int n);
        if (n % 8 == 0)      return 8'h00;
        else if (n % 8 == 1) return 8'hFF;
        else                 return 8'((n * 53 + 17) & 255);
    endfunction

    function automatic logic [3:0] exp_chan(logic [7:0] b, int k);
        if (b[4]) return {b[3:2], 2'(k)};
        else      return b[3:0];
    endfunction

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Converter core model
    int         nst = 0;
    logic [3:0] chlog [0:1023];
    int         busy_n = 0;
    int         cnt = 0;
    bit         busy = 0;
    bit         acc = 0;

    initial begin
        conv_done = 1'b0;
        conv_data = '0;
        forever begin
            @(posedge clk); #3;
            if (conv_done && acc) conv_done = 1'b0;
            acc = 0;
            if (busy) begin
                if (cnt == 0) begin
                    conv_done = 1'b1;
                    conv_data = dfun(busy_n);
                    busy = 0;
                end else cnt--;
            end
            if (conv_start) begin
                busy   = 1;
                cnt    = LAT;
                busy_n = nst;
                if (nst < 1024) chlog[nst] = chan_sel;
                nst++;
            end
            if (conv_done) acc = !suspend;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] b);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = b;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R2 fields", int'(status[5:0]), int'(b[5:0]));
        chk("R2 bit6", int'(status[6]), 0);
        chk("R2 flag clear", int'(status[7]), 0);
        if (pwr_en && !suspend) chk("R3 start", int'(conv_start), 1);
    endtask

    task automatic wait_starts(int target);
        int t = 0;
        while (nst < target && t < 3000) begin @(posedge clk); #3; t++; end
    endtask

    task automatic wait_flag();
        int t = 0;
        while (!status[7] && t < 3000) begin @(posedge clk); #3; t++; end
    endtask

    task automatic run_oneshot(logic [7:0] b);
        int n0;
        n0 = nst;
        wr(b);
        wait_flag();
        chk("R7 flag set", int'(status[7]), 1);
        cyc(12);
        chk("R6 stops", nst, n0 + 4);
        for (int k = 0; k < 4; k++) begin
            chk(b[4] ? "R5 chan" : "R4 chan", int'(chlog[n0 + k]), int'(exp_chan(b, k)));
            chk("R6 R12 slot", int'(results[k*8 +: 8]), int'(dfun(n0 + k)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int n0;
        logic [31:0] snap;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        chk("R1 status", int'(status), 0);
        chk("R1 results", int'(results), 0);
        chk("R1 start", int'(conv_start), 0);

        // R4 R5 R6: sweep all one-pass settings; bits 7..6 written nonzero to show they are ignored
        for (int c = 0; c < 32; c++) begin
            run_oneshot({2'(c), 1'b0, 5'(c)});
        end

        // R8: single-channel scan wraps and overwrites
        n0 = nst;
        wr(8'h25);
        wait_starts(n0 + 7);
        chk("R8 keeps running", int'(nst >= n0 + 7), 1);
        chk("R7 flag in scan", int'(status[7]), 1);
        chk("R8 slot0 overwritten", int'(results[7:0]), int'(dfun(n0 + 4)));
        chk("R8 slot1 overwritten", int'(results[15:8]), int'(dfun(n0 + 5)));
        chk("R8 slot2 older", int'(results[23:16]), int'(dfun(n0 + 2)));
        chk("R8 slot3 older", int'(results[31:24]), int'(dfun(n0 + 3)));

        // R8: multi-channel scan cycles through the group
        n0 = nst;
        wr(8'h3B);
        wait_starts(n0 + 9);
        for (int k = 0; k < 8; k++)
            chk("R8 R5 scan chan", int'(chlog[n0 + k]), int'({2'b10, 2'(k % 4)}));
        chk("R7 flag held", int'(status[7]), 1);

        // R9: write during an outstanding conversion restarts at slot 0
        n0 = nst;
        wr(8'h02);
        wait_starts(n0 + 2);
        cyc(1);
        n0 = nst;
        wr(8'h14);
        wait_flag();
        cyc(10);
        chk("R9 restart count", nst, n0 + 4);
        for (int k = 0; k < 4; k++) begin
            chk("R9 chan", int'(chlog[n0 + k]), int'({2'b01, 2'(k)}));
            chk("R9 slot", int'(results[k*8 +: 8]), int'(dfun(n0 + k)));
        end

        // R10: unpowered writes are stored but issue nothing
        pwr_en = 1'b0;
        n0 = nst;
        wr(8'h07);
        cyc(20);
        chk("R10 no start", nst, n0);
        chk("R10 stored", int'(status[5:0]), 7);
        chk("R10 flag low", int'(status[7]), 0);
        pwr_en = 1'b1;
        wait_flag();
        cyc(10);
        chk("R10 runs after power", nst, n0 + 4);
        for (int k = 0; k < 4; k++)
            chk("R10 slot", int'(results[k*8 +: 8]), int'(dfun(n0 + k)));

        // R11: suspend mid-pass
        n0 = nst;
        wr(8'h09);
        wait_starts(n0 + 2);
        cyc(LAT + 1);
        suspend = 1'b1;
        cyc(1);
        snap = results;
        cyc(30);
        chk("R11 no start", int'(nst <= n0 + 3), 1);
        chk("R11 results frozen", int'(results == snap), 1);
        chk("R11 flag low", int'(status[7]), 0);
        suspend = 1'b0;
        wait_flag();
        cyc(10);
        chk("R11 resume count", nst, n0 + 4);
        for (int k = 0; k < 4; k++) begin
            chk("R11 chan", int'(chlog[n0 + k]), 9);
            chk("R11 slot", int'(results[k*8 +: 8]), int'(dfun(n0 + k)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule